// File: doc/BRIEF.md
# Data Access Translation and Fault Checker

This block takes one data memory request per cycle and decides whether it may proceed. It produces the physical address, or a fault code with the two words that fault handling software reads. The request carries a virtual address, bit 0 of the program counter, a write flag, an access size and two request flags. One flag selects the alternate privilege mode. The other marks a page-table-entry fetch.

The page lookup runs outside this block. Its result arrives on the same cycle as the request: a hit bit, the page frame number, per-mode read and write enable masks, and the fault-on-read and fault-on-write bits.

The checks run in a fixed priority order. Misalignment comes first, then an address with unimplemented upper bits, then the direct-mapped window, then a lookup miss, then permissions, then an out-of-range physical address. The result is registered and appears one cycle after the request.

Top module: `dtx_translate`

## Requirements
- R1: While `rst_n` is low and after its release, `rsp_valid` is 0 and `rsp_fault`, `rsp_pa`, `rsp_stat` and `rsp_va_form` are all 0, until the first request.
- R2: A request accepted with `req_valid` high at a clock edge gives `rsp_valid` high after that edge. `rsp_valid` is low after any edge where `req_valid` is low.
- R3: The size code is log2 of the byte count (0=1, 1=2, 2=4, 3=8). An address not aligned to that size gives fault code 1 (alignment), overriding every other check. The status and form words are then 0. A byte access at an odd address does not fault.
- R4: The effective mode is a 2-bit index (0 = kernel). When `req_pc0` is 1 it is `alt_mode` if `req_altmode` is set, else kernel. When `req_pc0` is 0 it is `cur_mode`.
- R5: If VA bits 63:43 are neither all zero nor all one, the fault code is 2 (access) with flags BAD_VA|ACV (0x22), plus WR (0x01) on a write.
- R6: If VA bits 47:41 equal 0x7E and the mode is kernel, no lookup is used. The PA is VA bits 43:0, with bits 43:40 forced to ones when bit 40 is 1, or cleared when bit 40 is 0.
- R7: A VA in that window in a non-kernel mode gives fault code 2 with flag ACV (0x02), plus WR on a write.
- R8: A lookup miss gives flag MISS (0x10), plus WR on a write. The fault code is 4 (double miss) when `req_vpte` is set, else 3 (miss).
- R9: On a permitted hit, the PA is the page frame number shifted left by 13 plus VA bits 12:0.
- R10: On a write whose enable bit for the mode is clear, the fault code is 2 with flags WR|ACV (0x03), plus FONW (0x08) if fault-on-write is set. A permitted write with fault-on-write set gives code 2 with WR|FONW (0x09).
- R11: On a read whose enable bit for the mode is clear, the fault code is 2 with flag ACV, plus FONR (0x04) if fault-on-read is set.
- R12: For codes 2, 3 and 4, `rsp_stat` = opcode<<11 | ra<<6 | flags, and `rsp_va_form` = `ptbase` | (VA bits 42:13 << 3). For all other codes both words are 0.
- R13: A hit whose computed PA has any bit at or above bit 44 set gives fault code 5 (machine check).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 64 | Data virtual address |
| req_pc0 | input | 1 | Program counter bit 0 (privileged-code marker) |
| req_write | input | 1 | Access is a store |
| req_size | input | 2 | log2 of access bytes |
| req_altmode | input | 1 | Use alternate mode in privileged code |
| req_vpte | input | 1 | Request is a page-table-entry fetch |
| cur_mode | input | 2 | Current-mode field |
| alt_mode | input | 2 | Alternate-mode field |
| inst_opcode | input | 6 | Opcode of the faulting instruction |
| inst_ra | input | 5 | Ra field of the faulting instruction |
| ptbase | input | 64 | Page-table base for the form word |
| tlb_hit | input | 1 | Lookup hit |
| tlb_ppn | input | 35 | Page frame number from lookup |
| tlb_rd_en | input | 4 | Read enable per mode |
| tlb_wr_en | input | 4 | Write enable per mode |
| tlb_fonr | input | 1 | Fault on read |
| tlb_fonw | input | 1 | Fault on write |
| rsp_valid | output | 1 | Result present |
| rsp_pa | output | 44 | Physical address (0 on fault) |
| rsp_fault | output | 3 | 0 none, 1 align, 2 access, 3 miss, 4 double miss, 5 machine check |
| rsp_stat | output | 32 | Fault status word |
| rsp_va_form | output | 64 | Faulting VA form word |

## Verification
The hardest cases to reach are the ones where several faults are possible at once and the priority order decides which is reported. Examples are a misaligned access that is also a miss, a direct-window address with no lookup hit, and a write that is permitted but marked fault-on-write. The bench sets up each of these in its own directed task by giving the request fields and the lookup result together. The window tests use a canonical negative address whose bits 47:41 equal 0x7E. These tests are run in both privileged-code mode and ordinary mode, so that the mode selection decides between mapping and fault. The machine-check test uses frame numbers just below and just at the 44-bit limit.

// File: rtl/dtx_pkg.sv
// Shared types for the data translation checker.
// Assumes a 6-bit fault flag vector whose bit values are fixed by software.
package dtx_pkg;
    typedef enum logic [2:0] {
        FLT_NONE   = 3'd0,
        FLT_ALIGN  = 3'd1,
        FLT_ACCESS = 3'd2,
        FLT_MISS   = 3'd3,
        FLT_DMISS  = 3'd4,
        FLT_MCHK   = 3'd5
    } fault_e;

    localparam int FLAG_W = 6;
    localparam logic [FLAG_W-1:0] FL_BADVA = 6'h20;
    localparam logic [FLAG_W-1:0] FL_MISS  = 6'h10;
    localparam logic [FLAG_W-1:0] FL_FONW  = 6'h08;
    localparam logic [FLAG_W-1:0] FL_FONR  = 6'h04;
    localparam logic [FLAG_W-1:0] FL_ACV   = 6'h02;
    localparam logic [FLAG_W-1:0] FL_WR    = 6'h01;
endpackage

// File: rtl/dtx_mode_sel.sv
// Picks the effective privilege mode for a data access.
// Assumes mode index 0 is kernel; privileged code is flagged by PC bit 0.
module dtx_mode_sel #(
    parameter int MODE_W = 2
) (
    input  logic              pc0,
    input  logic              altmode,
    input  logic [MODE_W-1:0] cur_mode,
    input  logic [MODE_W-1:0] alt_mode,
    output logic [MODE_W-1:0] mode
);
    // Privileged code uses kernel or the alternate field; otherwise the current field.
    always_comb begin
        if (pc0)
            mode = altmode ? alt_mode : '0;
        else
            mode = cur_mode;
    end
endmodule

// File: rtl/dtx_va_check.sv
// Classifies a virtual address: implemented-range test, direct-window
// detection, and the direct-window physical address with sign extension.
// Assumes EXT_BIT < PA_W <= VA_W.
module dtx_va_check #(
    parameter int          VA_W    = 64,
    parameter int          VA_IMPL = 43,
    parameter int          PA_W    = 44,
    parameter int          WIN_LSB = 41,
    parameter int          WIN_W   = 7,
    parameter logic [6:0]  WIN_TAG = 7'h7e,
    parameter int          EXT_BIT = 40
) (
    input  logic [VA_W-1:0] va,
    output logic            canonical,
    output logic            in_window,
    output logic [PA_W-1:0] win_pa
);
    localparam int HI_W = VA_W - VA_IMPL;
    logic [HI_W-1:0] hi_bits;

    // Upper unimplemented bits must be uniform.
    always_comb begin
        hi_bits   = va[VA_W-1:VA_IMPL];
        canonical = (&hi_bits) || !(|hi_bits);
    end

    // Window match on the space-select field.
    always_comb in_window = (va[WIN_LSB +: WIN_W] == WIN_TAG[WIN_W-1:0]);

    // Bits above EXT_BIT copy EXT_BIT; the rest pass through.
    for (genvar i = 0; i < PA_W; i++) begin : g_ext
        if (i > EXT_BIT) begin : g_hi
            assign win_pa[i] = va[EXT_BIT];
        end else begin : g_lo
            assign win_pa[i] = va[i];
        end
    end
endmodule

// File: rtl/dtx_perm.sv
// Evaluates page permissions and fault-on bits for a lookup hit.
// Assumes one enable bit per mode, indexed by the mode number.
module dtx_perm
    import dtx_pkg::*;
#(
    parameter int MODES  = 4,
    parameter int MODE_W = $clog2(MODES)
) (
    input  logic [MODE_W-1:0] mode,
    input  logic              write,
    input  logic [MODES-1:0]  rd_en,
    input  logic [MODES-1:0]  wr_en,
    input  logic              fonr,
    input  logic              fonw,
    output logic              denied,
    output logic [FLAG_W-1:0] flags
);
    // Write checks enable then fault-on-write; read checks enable only.
    always_comb begin
        denied = 1'b0;
        flags  = '0;
        if (write) begin
            if (!wr_en[mode]) begin
                denied = 1'b1;
                flags  = FL_WR | FL_ACV | (fonw ? FL_FONW : '0);
            end else if (fonw) begin
                denied = 1'b1;
                flags  = FL_WR | FL_FONW;
            end
        end else if (!rd_en[mode]) begin
            denied = 1'b1;
            flags  = FL_ACV | (fonr ? FL_FONR : '0);
        end
    end
endmodule

// File: rtl/dtx_translate.sv
// Data access translation and fault checker. Combines alignment, address
// range, direct window, lookup result and permissions in fixed priority,
// then registers PA, fault code, status word and form word.
// Assumes the lookup result is valid in the same cycle as the request.
module dtx_translate
    import dtx_pkg::*;
#(
    parameter int VA_W       = 64,
    parameter int VA_IMPL    = 43,
    parameter int PA_W       = 44,
    parameter int PAGE_SHIFT = 13,
    parameter int PPN_IN_W   = 35,
    parameter int MODES      = 4,
    parameter int STAT_W     = 32,
    parameter int OPC_W      = 6,
    parameter int RA_W       = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [VA_W-1:0]     req_va,
    input  logic                req_pc0,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic                req_altmode,
    input  logic                req_vpte,
    input  logic [1:0]          cur_mode,
    input  logic [1:0]          alt_mode,
    input  logic [OPC_W-1:0]    inst_opcode,
    input  logic [RA_W-1:0]     inst_ra,
    input  logic [VA_W-1:0]     ptbase,
    input  logic                tlb_hit,
    input  logic [PPN_IN_W-1:0] tlb_ppn,
    input  logic [MODES-1:0]    tlb_rd_en,
    input  logic [MODES-1:0]    tlb_wr_en,
    input  logic                tlb_fonr,
    input  logic                tlb_fonw,
    output logic                rsp_valid,
    output logic [PA_W-1:0]     rsp_pa,
    output logic [2:0]          rsp_fault,
    output logic [STAT_W-1:0]   rsp_stat,
    output logic [VA_W-1:0]     rsp_va_form
);
    localparam int MODE_W  = $clog2(MODES);
    localparam int FULL_W  = PPN_IN_W + PAGE_SHIFT;
    localparam int VPN_W   = VA_IMPL - PAGE_SHIFT;
    localparam int STAT_UW = OPC_W + RA_W + FLAG_W;

    logic [MODE_W-1:0] mode;
    logic              canonical, in_window, misaligned, perm_denied, mchk;
    logic [PA_W-1:0]   win_pa;
    logic [FLAG_W-1:0] perm_flags, flags;
    logic [FULL_W-1:0] tlb_pa;
    logic [VPN_W-1:0]  vpn;
    fault_e            fault;
    logic [PA_W-1:0]   pa_n;
    logic [FLAG_W-1:0] wr_flag;

    dtx_mode_sel #(.MODE_W(MODE_W)) u_mode (
        .pc0(req_pc0), .altmode(req_altmode),
        .cur_mode(cur_mode[MODE_W-1:0]), .alt_mode(alt_mode[MODE_W-1:0]),
        .mode(mode)
    );

    dtx_va_check #(.VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W)) u_va (
        .va(req_va), .canonical(canonical), .in_window(in_window),
        .win_pa(win_pa)
    );

    dtx_perm #(.MODES(MODES), .MODE_W(MODE_W)) u_perm (
        .mode(mode), .write(req_write), .rd_en(tlb_rd_en), .wr_en(tlb_wr_en),
        .fonr(tlb_fonr), .fonw(tlb_fonw), .denied(perm_denied),
        .flags(perm_flags)
    );

    // Size-dependent low-address alignment test.
    always_comb begin
        case (req_size)
            2'd0:    misaligned = 1'b0;
            2'd1:    misaligned = req_va[0];
            2'd2:    misaligned = |req_va[1:0];
            default: misaligned = |req_va[2:0];
        endcase
    end

    // Frame number joined with the page offset.
    always_comb begin
        tlb_pa = {tlb_ppn, req_va[PAGE_SHIFT-1:0]};
        vpn    = req_va[VA_IMPL-1:PAGE_SHIFT];
    end

    // Out-of-range test only exists when the frame can exceed the PA width.
    if (FULL_W > PA_W) begin : g_mchk
        assign mchk = |tlb_pa[FULL_W-1:PA_W];
    end else begin : g_nomchk
        assign mchk = 1'b0;
    end

    // Prioritised fault decision and physical address selection.
    always_comb begin
        wr_flag = req_write ? FL_WR : '0;
        fault   = FLT_NONE;
        flags   = '0;
        pa_n    = '0;
        if (misaligned) begin
            fault = FLT_ALIGN;
        end else if (!canonical) begin
            fault = FLT_ACCESS;
            flags = FL_BADVA | FL_ACV | wr_flag;
        end else if (in_window) begin
            if (mode != '0) begin
                fault = FLT_ACCESS;
                flags = FL_ACV | wr_flag;
            end else begin
                pa_n = win_pa;
            end
        end else if (!tlb_hit) begin
            fault = req_vpte ? FLT_DMISS : FLT_MISS;
            flags = FL_MISS | wr_flag;
        end else if (perm_denied) begin
            fault = FLT_ACCESS;
            flags = perm_flags;
        end else if (mchk) begin
            fault = FLT_MCHK;
        end else begin
            pa_n = tlb_pa[PA_W-1:0];
        end
    end

    // Result register; holds the last result between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_pa      <= '0;
            rsp_fault   <= '0;
            rsp_stat    <= '0;
            rsp_va_form <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_pa    <= pa_n;
                rsp_fault <= fault;
                if (flags != '0) begin
                    rsp_stat    <= {{(STAT_W-STAT_UW){1'b0}}, inst_opcode, inst_ra, flags};
                    rsp_va_form <= ptbase | {{(VA_W-VPN_W-3){1'b0}}, vpn, 3'b000};
                end else begin
                    rsp_stat    <= '0;
                    rsp_va_form <= '0;
                end
            end
        end
    end
endmodule

// File: rtl/dtx_translate_chk.sv
// Property checker for dtx_translate, attached by bind.
module dtx_translate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [63:0] req_va,
    input logic        req_write,
    input logic [1:0]  req_size,
    input logic        rsp_valid,
    input logic [2:0]  rsp_fault,
    input logic [31:0] rsp_stat,
    input logic [63:0] rsp_va_form
);
    logic odd_addr;
    always_comb odd_addr = (req_size == 2'd1 && req_va[0]) ||
                           (req_size == 2'd2 && req_va[1:0] != 2'b00) ||
                           (req_size == 2'd3 && req_va[2:0] != 3'b000);

    a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    a_r3_align_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && odd_addr) |=> rsp_fault == 3'd1);
    a_r8_miss_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == 3'd3 || rsp_fault == 3'd4)) |-> rsp_stat[4]);
    a_r12_quiet_words: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault == 3'd0 || rsp_fault == 3'd1 || rsp_fault == 3'd5))
        |-> (rsp_stat == 32'd0 && rsp_va_form == 64'd0));
    a_r10_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_stat[5:0] == 6'd0 || rsp_stat[0]));
    a_r11_read_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> (!rsp_stat[0] && !rsp_stat[3]));
endmodule

bind dtx_translate dtx_translate_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_write(req_write), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_stat(rsp_stat), .rsp_va_form(rsp_va_form)
);

// File: tb/dtx_translate_test.sv
module dtx_translate_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_pc0, req_write, req_altmode, req_vpte;
    logic [63:0] req_va, ptbase;
    logic [1:0]  req_size, cur_mode, alt_mode;
    logic [5:0]  inst_opcode;
    logic [4:0]  inst_ra;
    logic        tlb_hit, tlb_fonr, tlb_fonw;
    logic [34:0] tlb_ppn;
    logic [3:0]  tlb_rd_en, tlb_wr_en;
    logic        rsp_valid;
    logic [43:0] rsp_pa;
    logic [2:0]  rsp_fault;
    logic [31:0] rsp_stat;
    logic [63:0] rsp_va_form;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    localparam logic [31:0] SBASE = 32'h16140; // opcode 0x2C, ra 5
    localparam logic [63:0] PTB   = 64'h2_0000_0000;

    always #2 clk = ~clk;

    dtx_translate uut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        req_valid = 0; req_va = 64'h2000; req_pc0 = 0; req_write = 0;
        req_size = 2'd3; req_altmode = 0; req_vpte = 0;
        cur_mode = 2'd0; alt_mode = 2'd0;
        inst_opcode = 6'h2c; inst_ra = 5'd5; ptbase = PTB;
        tlb_hit = 1; tlb_ppn = 35'h42; tlb_rd_en = 4'hf; tlb_wr_en = 4'hf;
        tlb_fonr = 0; tlb_fonw = 0;
    endtask

    task automatic fire();
        @(negedge clk) req_valid = 1;
        @(negedge clk) req_valid = 0;
    endtask

    task automatic t_reset();
        defaults(); rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 valid", {63'd0, rsp_valid}, 0);
        chk("R1 fault", {61'd0, rsp_fault}, 0);
        chk("R1 pa", {20'd0, rsp_pa}, 0);
        chk("R1 stat", {32'd0, rsp_stat}, 0);
        chk("R1 form", rsp_va_form, 0);
    endtask

    task automatic t_hit();
        defaults(); req_va = 64'h0123_4568; tlb_rd_en = 4'b0001;
        fire();
        chk("R2 valid", {63'd0, rsp_valid}, 1);
        chk("R9 fault", {61'd0, rsp_fault}, 0);
        chk("R9 pa", {20'd0, rsp_pa}, 64'h8_4568);
        @(negedge clk);
        chk("R2 idle", {63'd0, rsp_valid}, 0);
        chk("R2 hold", {20'd0, rsp_pa}, 64'h8_4568);
    endtask

    task automatic t_align();
        defaults(); req_va = 64'h0123_4566; req_size = 2'd2; tlb_hit = 0;
        fire();
        chk("R3 code", {61'd0, rsp_fault}, 1);
        chk("R3 stat", {32'd0, rsp_stat}, 0);
        defaults(); req_va = 64'h0123_4567; req_size = 2'd0;
        fire();
        chk("R3 byte ok", {61'd0, rsp_fault}, 0);
    endtask

    task automatic t_range();
        defaults(); req_va = 64'h0001_0000_0000_0000; req_write = 1;
        fire();
        chk("R5 code", {61'd0, rsp_fault}, 2);
        chk("R5 stat", {32'd0, rsp_stat}, SBASE | 32'h23);
        defaults(); req_va = 64'hFFFF_F800_0000_2000; tlb_hit = 0;
        fire();
        chk("R8 miss code", {61'd0, rsp_fault}, 3);
        chk("R8 stat", {32'd0, rsp_stat}, SBASE | 32'h10);
        chk("R12 form", rsp_va_form, PTB | 64'h8);
    endtask

    task automatic t_dmiss();
        defaults(); req_va = 64'h6000; req_write = 1; req_vpte = 1; tlb_hit = 0;
        fire();
        chk("R8 dmiss code", {61'd0, rsp_fault}, 4);
        chk("R8 dmiss stat", {32'd0, rsp_stat}, SBASE | 32'h11);
        chk("R12 dmiss form", rsp_va_form, PTB | 64'h18);
    endtask

    task automatic t_window();
        defaults(); req_va = 64'hFFFF_FD00_1234_5670; tlb_hit = 0;
        req_pc0 = 1; cur_mode = 2'd3;
        fire();
        chk("R6 code ext", {61'd0, rsp_fault}, 0);
        chk("R6 pa ext", {20'd0, rsp_pa}, 64'hF00_1234_5670);
        req_va = 64'hFFFF_FC80_0000_1000;
        fire();
        chk("R6 pa trunc", {20'd0, rsp_pa}, 64'h80_0000_1000);
        req_pc0 = 0; req_write = 1;
        fire();
        chk("R7 code", {61'd0, rsp_fault}, 2);
        chk("R7 stat", {32'd0, rsp_stat}, SBASE | 32'h03);
        chk("R12 window form", rsp_va_form, 64'h3_2000_0000);
    endtask

    task automatic t_altmode();
        defaults(); req_pc0 = 1; req_altmode = 1; alt_mode = 2'd3; cur_mode = 2'd0;
        tlb_rd_en = 4'b0001; tlb_fonr = 1;
        fire();
        chk("R4 alt code", {61'd0, rsp_fault}, 2);
        chk("R11 fonr stat", {32'd0, rsp_stat}, SBASE | 32'h06);
        req_altmode = 0;
        fire();
        chk("R4 pal kernel", {61'd0, rsp_fault}, 0);
    endtask

    task automatic t_write_perm();
        defaults(); req_write = 1; tlb_wr_en = 4'b0000; tlb_fonw = 1;
        fire();
        chk("R10 deny fonw", {32'd0, rsp_stat}, SBASE | 32'h0B);
        tlb_wr_en = 4'b0001;
        fire();
        chk("R10 fonw only", {32'd0, rsp_stat}, SBASE | 32'h09);
        chk("R10 fonw code", {61'd0, rsp_fault}, 2);
        tlb_fonw = 0;
        fire();
        chk("R10 allowed", {61'd0, rsp_fault}, 0);
    endtask

    task automatic t_read_perm();
        defaults(); cur_mode = 2'd3; tlb_rd_en = 4'b0111;
        fire();
        chk("R11 deny", {32'd0, rsp_stat}, SBASE | 32'h02);
        tlb_rd_en = 4'b1000;
        fire();
        chk("R11 allowed", {61'd0, rsp_fault}, 0);
    endtask

    task automatic t_mchk();
        defaults(); req_va = 64'h0; tlb_ppn = 35'h8000_0000;
        fire();
        chk("R13 code", {61'd0, rsp_fault}, 5);
        chk("R13 stat", {32'd0, rsp_stat}, 0);
        tlb_ppn = 35'h7FFF_FFFF;
        fire();
        chk("R13 edge code", {61'd0, rsp_fault}, 0);
        chk("R13 edge pa", {20'd0, rsp_pa}, 64'hFFF_FFFF_E000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R2 watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hit();
        t_align();
        t_range();
        t_dmiss();
        t_window();
        t_altmode();
        t_write_perm();
        t_read_perm();
        t_mchk();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule